// File: doc/BRIEF.md
# Move Elimination Decision Unit

At rename time, this unit decides whether each register-to-register move in a rename group can be retired without a new physical register. An accepted move makes its destination an alias of the move's source. The unit keeps an alias table and a known-zero bit for every architectural register. For each register file it also enforces a per-cycle budget and an optional mode that eliminates only moves whose source is known to be zero.

Registers come in pairs. An even index is a wide register, and the odd index above it is that register's lower half. The lower half is renamed as its wide partner. Register files are contiguous blocks of `REGS_PER_FILE` indices. Each cycle, up to `NUM_LANES` operations are evaluated in program order, with lane 0 the oldest. Every lane sees the budget use and the table updates of the lanes before it. A read-side lookup port gives the register that a read of a given register depends on, and whether that register is known to be zero.

Top module: `move_elim_unit`

## Requirements
- R1: After reset no register has an alias (`look_dep` equals `look_reg`), no register is known zero, and `accept` and `zero_move` are low whenever no lane is valid.
- R2: A move whose source and destination sit in different files (file = index / REGS_PER_FILE) is rejected.
- R3: A move to an odd (lower-half) destination is accepted only when `elim_ok` of its even partner is set and `op_clr_upper` is set. An even destination has no such condition.
- R4: Each file accepts at most `file_max` moves per cycle, counted against the source's file. A limit of 0 means no limit. The count starts from zero every cycle.
- R5: A file with `zero_only` set accepts a move only when the source register is known zero.
- R6: The alias target is found in three steps. Start from the source. For an odd source, take its even partner. If that register has an alias, take that alias once.
- R7: An accepted move writes the target into the alias of the destination, and of destination+1 when the destination is even. When the target equals the destination, the existing aliases are left unchanged.
- R8: `zero_move` is high when a move is accepted and its source is known zero. The destination's known-zero bits are then set. An accepted move from a non-zero source clears them.
- R9: A valid operation that is not an accepted move clears the aliases of both registers in the destination pair. Its known-zero bits are set for a zero-idiom non-move and cleared otherwise. These bits cover the whole pair unless the destination is odd and `op_clr_upper` is low, in which case only the destination is affected.
- R10: Lanes act in program order. The budget goes to the lowest accepted lanes first, and a later lane sees the alias and zero state left by earlier lanes in the same cycle.
- R11: A lane with `op_valid` low is never accepted and changes no state. `op_zero_idiom` has no effect on moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | NUM_LANES | Lane carries an operation |
| op_is_move | input | NUM_LANES | Operation is a register move candidate |
| op_src | input | NUM_LANES x REG_W | Move source register |
| op_dst | input | NUM_LANES x REG_W | Destination register |
| op_clr_upper | input | NUM_LANES | Write clears the upper part of the wide register |
| op_zero_idiom | input | NUM_LANES | Non-move write produces zero |
| file_max | input | NUM_FILES x BUDGET_W | Per-file eliminations per cycle, 0 = unlimited |
| zero_only | input | NUM_FILES | File eliminates only known-zero sources |
| elim_ok | input | NUM_REGS | Per-register move-elimination permission |
| look_reg | input | REG_W | Register to look up |
| look_dep | output | REG_W | Register a read of `look_reg` depends on |
| look_zero | output | 1 | `look_reg` is known zero |
| accept | output | NUM_LANES | Move eliminated |
| zero_move | output | NUM_LANES | Eliminated move copies a known zero |

## Verification
The assertions assume that source and destination indices are below `NUM_REGS`, and that the configuration inputs stay stable within a cycle. The budget check also relies on the file being taken from the source register, which is only sound because a move across files is never accepted. The stimulus draws every register index from the valid range and changes the configuration only between clock edges. It mixes directed sequences, such as alias chains, the equal-target case and budget exhaustion across lanes, with long random runs against an arithmetic model of the requirements.

// File: rtl/move_elim_pkg.sv
package move_elim_pkg;
    parameter int NUM_REGS   = 12;
    parameter int NUM_FILES  = 2;
    parameter int NUM_LANES  = 2;
    parameter int BUDGET_W   = 3;

    localparam int REG_W         = $clog2(NUM_REGS);
    localparam int FILE_W        = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1;
    localparam int REGS_PER_FILE = NUM_REGS / NUM_FILES;

    typedef logic [REG_W-1:0] reg_id_t;
    typedef logic [FILE_W-1:0] file_id_t;
    typedef logic [NUM_FILES-1:0][BUDGET_W-1:0] budget_t;

    typedef struct packed {
        logic    valid;
        logic    is_move;
        reg_id_t src;
        reg_id_t dst;
        logic    clr_upper;
        logic    zero_idiom;
    } rn_op_t;

    typedef struct packed {
        logic [NUM_REGS-1:0]               alias_v;
        logic [NUM_REGS-1:0][REG_W-1:0]    alias_tgt;
        logic [NUM_REGS-1:0]               zero;
    } rn_map_t;

    function automatic logic is_low_half(reg_id_t r);
        return r[0];
    endfunction

    function automatic reg_id_t pair_base(reg_id_t r);
        return {r[REG_W-1:1], 1'b0};
    endfunction

    function automatic reg_id_t pair_top(reg_id_t r);
        return {r[REG_W-1:1], 1'b1};
    endfunction

    function automatic file_id_t file_of(reg_id_t r);
        return FILE_W'(int'(r) / REGS_PER_FILE);
    endfunction
endpackage

// File: rtl/move_elim_lane.sv
module move_elim_lane
    import move_elim_pkg::*;
(
    input  rn_op_t                 op,
    input  budget_t                used_in,
    input  rn_map_t                map_in,
    input  budget_t                file_max,
    input  logic [NUM_FILES-1:0]   zero_only,
    input  logic [NUM_REGS-1:0]    elim_ok,
    output logic                   accept,
    output logic                   zero_move,
    output budget_t                used_out,
    output rn_map_t                map_out
);
    file_id_t src_file;
    file_id_t dst_file;
    logic     src_zero;
    logic     width_ok;
    logic     budget_ok;
    logic     zero_ok;
    logic     whole_pair;
    logic     new_zero;
    reg_id_t  root;
    reg_id_t  base_r;
    reg_id_t  top_r;

    always_comb begin
        src_file  = file_of(op.src);
        dst_file  = file_of(op.dst);
        src_zero  = map_in.zero[op.src];
        base_r    = pair_base(op.dst);
        top_r     = pair_top(op.dst);
        width_ok  = !is_low_half(op.dst) || (elim_ok[base_r] && op.clr_upper);
        budget_ok = (file_max[src_file] == '0) || (used_in[src_file] != file_max[src_file]);
        zero_ok   = !zero_only[src_file] || src_zero;
        accept    = op.valid && op.is_move && (src_file == dst_file)
                    && width_ok && budget_ok && zero_ok;
        zero_move = accept && src_zero;

        root = is_low_half(op.src) ? pair_base(op.src) : op.src;
        if (map_in.alias_v[root])
            root = map_in.alias_tgt[root];

        whole_pair = !is_low_half(op.dst) || op.clr_upper;
        new_zero   = accept ? src_zero : (!op.is_move && op.zero_idiom);

        map_out  = map_in;
        used_out = used_in;
        if (op.valid) begin
            if (whole_pair) begin
                map_out.zero[base_r] = new_zero;
                map_out.zero[top_r]  = new_zero;
            end else begin
                map_out.zero[op.dst] = new_zero;
            end
            if (accept) begin
                used_out[src_file] = used_in[src_file] + BUDGET_W'(1);
                if (root != op.dst) begin
                    map_out.alias_v[op.dst]   = 1'b1;
                    map_out.alias_tgt[op.dst] = root;
                    if (!is_low_half(op.dst)) begin
                        map_out.alias_v[top_r]   = 1'b1;
                        map_out.alias_tgt[top_r] = root;
                    end
                end
            end else begin
                map_out.alias_v[base_r] = 1'b0;
                map_out.alias_v[top_r]  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/move_elim_map_reg.sv
module move_elim_map_reg
    import move_elim_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rn_map_t map_d,
    output rn_map_t map_q
);
    always_ff @(posedge clk) begin
        if (rst)
            map_q <= '0;
        else
            map_q <= map_d;
    end
endmodule

// File: rtl/move_elim_unit.sv
module move_elim_unit
    import move_elim_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LANES-1:0]              op_valid,
    input  logic [NUM_LANES-1:0]              op_is_move,
    input  logic [NUM_LANES-1:0][REG_W-1:0]   op_src,
    input  logic [NUM_LANES-1:0][REG_W-1:0]   op_dst,
    input  logic [NUM_LANES-1:0]              op_clr_upper,
    input  logic [NUM_LANES-1:0]              op_zero_idiom,
    input  logic [NUM_FILES-1:0][BUDGET_W-1:0] file_max,
    input  logic [NUM_FILES-1:0]              zero_only,
    input  logic [NUM_REGS-1:0]               elim_ok,
    input  logic [REG_W-1:0]                  look_reg,
    output logic [REG_W-1:0]                  look_dep,
    output logic                              look_zero,
    output logic [NUM_LANES-1:0]              accept,
    output logic [NUM_LANES-1:0]              zero_move
);
    rn_map_t map_q;
    rn_map_t chain_map  [NUM_LANES+1];
    budget_t chain_used [NUM_LANES+1];

    assign chain_map[0]  = map_q;
    assign chain_used[0] = '0;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        rn_op_t lane_op;
        assign lane_op = '{valid:      op_valid[l],
                           is_move:    op_is_move[l],
                           src:        op_src[l],
                           dst:        op_dst[l],
                           clr_upper:  op_clr_upper[l],
                           zero_idiom: op_zero_idiom[l]};

        move_elim_lane u_lane (
            .op        (lane_op),
            .used_in   (chain_used[l]),
            .map_in    (chain_map[l]),
            .file_max  (file_max),
            .zero_only (zero_only),
            .elim_ok   (elim_ok),
            .accept    (accept[l]),
            .zero_move (zero_move[l]),
            .used_out  (chain_used[l+1]),
            .map_out   (chain_map[l+1])
        );
    end

    move_elim_map_reg u_map (
        .clk   (clk),
        .rst   (rst),
        .map_d (chain_map[NUM_LANES]),
        .map_q (map_q)
    );

    assign look_dep  = map_q.alias_v[look_reg] ? map_q.alias_tgt[look_reg] : look_reg;
    assign look_zero = map_q.zero[look_reg];
endmodule

// File: rtl/move_elim_checker.sv
module move_elim_checker
    import move_elim_pkg::*;
(
    input logic                               clk,
    input logic                               rst,
    input logic [NUM_LANES-1:0]               op_valid,
    input logic [NUM_LANES-1:0]               op_is_move,
    input logic [NUM_LANES-1:0][REG_W-1:0]    op_src,
    input logic [NUM_LANES-1:0][REG_W-1:0]    op_dst,
    input logic [NUM_FILES-1:0][BUDGET_W-1:0] file_max,
    input logic [NUM_FILES-1:0]               zero_only,
    input logic [NUM_LANES-1:0]               accept,
    input logic [NUM_LANES-1:0]               zero_move
);
    logic budget_fine;

    always_comb begin
        budget_fine = 1'b1;
        for (int f = 0; f < NUM_FILES; f++) begin
            int n;
            n = 0;
            for (int l = 0; l < NUM_LANES; l++)
                if (accept[l] && (int'(file_of(op_src[l])) == f))
                    n++;
            if (file_max[f] != '0 && n > int'(file_max[f]))
                budget_fine = 1'b0;
        end
    end

    // R4: per-file acceptances never exceed a nonzero limit
    assert_budget_held_R4: assert property (@(posedge clk) disable iff (rst)
        budget_fine);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
        assert_accept_needs_move_R11: assert property (@(posedge clk) disable iff (rst)
            accept[l] |-> (op_valid[l] && op_is_move[l]));

        assert_same_file_R2: assert property (@(posedge clk) disable iff (rst)
            accept[l] |-> (file_of(op_src[l]) == file_of(op_dst[l])));

        assert_zero_only_mode_R5: assert property (@(posedge clk) disable iff (rst)
            (accept[l] && zero_only[file_of(op_src[l])]) |-> zero_move[l]);

        assert_zero_move_accepted_R8: assert property (@(posedge clk) disable iff (rst)
            zero_move[l] |-> accept[l]);
    end
endmodule

bind move_elim_unit move_elim_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_is_move (op_is_move),
    .op_src     (op_src),
    .op_dst     (op_dst),
    .file_max   (file_max),
    .zero_only  (zero_only),
    .accept     (accept),
    .zero_move  (zero_move)
);

// File: tb/move_elim_unit_test.sv
`timescale 1ns/10ps
module move_elim_unit_test;
    import move_elim_pkg::*;

    localparam int NR = NUM_REGS;
    localparam int NL = NUM_LANES;
    localparam int NF = NUM_FILES;
    localparam int PF = REGS_PER_FILE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NL-1:0]              op_valid = '0;
    logic [NL-1:0]              op_is_move = '0;
    logic [NL-1:0][REG_W-1:0]   op_src = '0;
    logic [NL-1:0][REG_W-1:0]   op_dst = '0;
    logic [NL-1:0]              op_clr_upper = '0;
    logic [NL-1:0]              op_zero_idiom = '0;
    logic [NF-1:0][BUDGET_W-1:0] file_max = '0;
    logic [NF-1:0]              zero_only = '0;
    logic [NR-1:0]              elim_ok = '1;
    logic [REG_W-1:0]           look_reg = '0;
    logic [REG_W-1:0]           look_dep;
    logic                       look_zero;
    logic [NL-1:0]              accept;
    logic [NL-1:0]              zero_move;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit m_av [NR];
    int m_at [NR];
    bit m_z  [NR];
    bit e_acc [NL];
    bit e_zm  [NL];

    always #2 clk = ~clk;

    move_elim_unit uut (.*);

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_eval();
        int used [NF];
        for (int f = 0; f < NF; f++) used[f] = 0;
        for (int l = 0; l < NL; l++) begin
            int s, d, b, t, lim;
            bit sz, ok, nz;
            s = int'(op_src[l]); d = int'(op_dst[l]); b = d - (d % 2);
            sz = m_z[s];
            lim = int'(file_max[s / PF]);
            ok = op_valid[l] && op_is_move[l] && (s / PF == d / PF)
                 && ((d % 2 == 0) || (elim_ok[b] && op_clr_upper[l]))
                 && (lim == 0 || used[s / PF] < lim)
                 && (!zero_only[s / PF] || sz);
            e_acc[l] = ok;
            e_zm[l]  = ok && sz;
            t = s - (s % 2);
            if (m_av[t]) t = m_at[t];
            nz = ok ? sz : (!op_is_move[l] && op_zero_idiom[l]);
            if (op_valid[l]) begin
                if (d % 2 == 0 || op_clr_upper[l]) begin m_z[b] = nz; m_z[b+1] = nz; end
                else m_z[d] = nz;
                if (ok) begin
                    used[s / PF]++;
                    if (t != d) begin
                        m_av[d] = 1; m_at[d] = t;
                        if (d % 2 == 0) begin m_av[d+1] = 1; m_at[d+1] = t; end
                    end
                end else begin
                    m_av[b] = 0; m_av[b+1] = 0;
                end
            end
        end
    endtask

    task automatic sweep(input string tag);
        for (int r = 0; r < NR; r++) begin
            int ed;
            look_reg = REG_W'(r);
            #0.1;
            ed = m_av[r] ? m_at[r] : r;
            chk(int'(look_dep) == ed, tag, $sformatf("look_dep[%0d]", r), int'(look_dep), ed);
            chk(look_zero == m_z[r], tag, $sformatf("look_zero[%0d]", r), int'(look_zero), int'(m_z[r]));
        end
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        #1;
        model_eval();
        for (int l = 0; l < NL; l++) begin
            chk(accept[l] == e_acc[l], tag, $sformatf("accept[%0d]", l), int'(accept[l]), int'(e_acc[l]));
            chk(zero_move[l] == e_zm[l], tag, $sformatf("zero_move[%0d]", l), int'(zero_move[l]), int'(e_zm[l]));
        end
        @(posedge clk);
        #0.1;
        op_valid = '0;
        sweep(tag);
    endtask

    task automatic set_op(input int l, input bit mv, input int s, input int d, input bit cu, input bit zi);
        op_valid[l] = 1'b1; op_is_move[l] = mv;
        op_src[l] = REG_W'(s); op_dst[l] = REG_W'(d);
        op_clr_upper[l] = cu; op_zero_idiom[l] = zi;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin m_av[r] = 0; m_at[r] = 0; m_z[r] = 0; end
        repeat (3) @(posedge clk);
        #0.1 rst = 1'b0;
        sweep("R1");
        step("R1");

        // R9: zero idiom on whole pair, then on a lone lower half
        set_op(0, 0, 0, 0, 0, 1); step("R9");
        set_op(0, 0, 0, 3, 0, 1); step("R9");
        // R8: zero move 0 -> 2
        set_op(0, 1, 0, 2, 0, 0); step("R8");
        // R6: odd source resolves via partner's alias (3 -> 2 -> 0)
        set_op(0, 1, 3, 4, 0, 0); step("R6");
        // R7: equal target keeps existing alias
        set_op(0, 1, 2, 0, 0, 0); step("R7");
        set_op(0, 1, 4, 2, 0, 0); step("R7");
        set_op(0, 1, 0, 2, 0, 0); step("R7");
        // R2: cross-file rejected, behaves as plain write
        set_op(0, 1, 6, 8, 0, 0); step("R2");
        set_op(0, 1, 0, 8, 0, 0); step("R2");
        // R3: lower-half destinations
        elim_ok[2] = 1'b0;
        set_op(0, 1, 0, 3, 1, 0); step("R3");
        elim_ok[2] = 1'b1;
        set_op(0, 1, 0, 3, 0, 0); step("R3");
        set_op(0, 1, 0, 3, 1, 0); step("R3");
        elim_ok[4] = 1'b0;
        set_op(0, 1, 0, 4, 0, 0); step("R3");
        elim_ok = '1;
        // R4: budget per file per cycle
        file_max[0] = 3'd1;
        set_op(0, 1, 0, 2, 0, 0); set_op(1, 1, 2, 4, 0, 0); step("R4");
        set_op(0, 1, 0, 2, 0, 0); step("R4");
        file_max[1] = 3'd1;
        set_op(0, 1, 6, 8, 0, 0); set_op(1, 1, 0, 4, 0, 0); step("R4");
        file_max = '0;
        set_op(0, 1, 0, 2, 0, 0); set_op(1, 1, 2, 4, 0, 0); step("R4");
        // R5: zero-only mode
        zero_only[0] = 1'b1;
        set_op(0, 0, 0, 0, 0, 0); step("R5");
        set_op(0, 1, 0, 2, 0, 0); step("R5");
        // R10: later lane sees earlier lane's zero idiom
        set_op(0, 0, 0, 0, 0, 1); set_op(1, 1, 0, 2, 0, 0); step("R10");
        zero_only = '0;
        // R11: invalid lane, and zero_idiom ignored on moves
        set_op(0, 1, 6, 10, 0, 0); op_valid[0] = 1'b0; step("R11");
        set_op(0, 1, 6, 10, 0, 1); step("R11");

        // R10: random mixed traffic in program order
        for (int c = 0; c < 2000; c++) begin
            if (c % 8 == 0) begin
                for (int f = 0; f < NF; f++) begin
                    file_max[f]  = BUDGET_W'($urandom_range(0, 2));
                    zero_only[f] = ($urandom_range(0, 3) == 0);
                end
                elim_ok = NR'($urandom);
            end
            for (int l = 0; l < NL; l++) begin
                int s, d;
                s = $urandom_range(0, NR - 1);
                d = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NR - 1)
                    : (s / PF) * PF + $urandom_range(0, PF - 1);
                set_op(l, ($urandom_range(0, 3) != 0), s, d,
                       $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0);
                op_valid[l] = ($urandom_range(0, 3) != 0);
            end
            step("R10");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule